// File: doc/BRIEF.md
# VID Output-Voltage Slew Sequencer

This block drives the 6-bit reference code of a step-down regulator's DAC. While the suspend line is low, the target is the 6-bit VID input. While it is high, the target comes from two four-level suspend selectors. The block does not jump to a new target. It walks the DAC code toward the target by one code, which is 25 mV, on each slew-clock strobe. Before the first step it spends one strobe as a start delay, and after the last step it spends one more strobe as a trailing period.

While a transition runs, the block holds the regulator in forced-PWM and blanks the power-good output by pulling its output enable low. Power-good comes back only after the code sits on target, the trailing strobe has passed, and a further eight strobes have passed. When the regulator is idle in suspend, pulse-skipping is forced. When it is idle and not suspended, the skip request picks the mode.

No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. Every input is a level that is sampled on each clock. `slew_tick` is a one-cycle enable strobe from an external slew oscillator.

Top module: `vid_slew_seq`

## Requirements
- R1: With `suspend` low the target equals `vid_code`. With `suspend` high the target is `sus_sel_hi*4 + sus_sel_lo`, and `vid_code` has no effect on `dac_code` or `pgood_oe`.
- R2: Codes are linear: code n means 0.275 V + n×25 mV, so code 0 is 0.275 V and code 63 is 1.850 V. The sixteen suspend targets are codes 0 to 15 (0.275 V to 0.650 V).
- R3: `dac_code` changes only on a clock where `slew_tick` is high, and only by plus or minus one. In the stepping phase each strobe moves it one code toward the target until it equals the target.
- R4: The first strobe after a transition starts from idle makes no step. The step comes on the second strobe.
- R5: A transition starts in any cycle where the target or the `suspend` level differs from its value in the previous cycle. In that same cycle `pgood_oe` is 0 and `force_pwm` is 1, and that start cycle ignores `slew_tick`.
- R6: Once `dac_code` reaches the target, one trailing strobe follows and then eight more strobes. `pgood_oe` is 1 from the clock edge of the eighth strobe onward. While `pgood_oe` is 0, `force_pwm` is 1.
- R7: When idle with `suspend` high, `force_pwm` is 0 whatever `skip_req` is.
- R8: When idle with `suspend` low, `force_pwm` equals `skip_req`, where 1 selects forced-PWM.
- R9: A target change during a transition does not reset the code. Stepping resumes from the present code without a new start delay, and the eight-strobe blanking count begins again.
- R10: While `rst_n` is low, `dac_code` loads the current target directly. After reset, `pgood_oe` stays 0 for eight strobes and no trailing strobe is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slew_tick | input | 1 | One-cycle slew-clock strobe |
| vid_code | input | 6 | VID target code |
| sus_sel_hi | input | 2 | Upper four-level suspend selector |
| sus_sel_lo | input | 2 | Lower four-level suspend selector |
| suspend | input | 1 | Suspend request |
| skip_req | input | 1 | 1 selects forced-PWM when idle and not suspended |
| dac_code | output | 6 | Present DAC reference code |
| pgood_oe | output | 1 | Power-good output enable (0 means high impedance) |
| force_pwm | output | 1 | 1 forces PWM, 0 selects pulse-skipping |

## Verification
The hardest state to reach is a retarget that lands in the trailing or blanking phase. The bench first walks a ramp onto its target strobe by strobe and stops partway through the eight-strobe blanking count. It then moves the VID code by one, so the stepping phase must resume without a delay and the count must start again. A second directed case changes the target mid-ramp in the opposite direction. Long runs of mixed VID, suspend and strobe activity follow, and a behavioural model checks every cycle of them.

// File: rtl/vid_slew_pkg.sv
package vid_slew_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DELAY = 3'd1,
    PH_STEP  = 3'd2,
    PH_TRAIL = 3'd3,
    PH_BLANK = 3'd4
  } phase_e;
endpackage

// File: rtl/vss_target_sel.sv
module vss_target_sel #(
  parameter int CODE_W = 6,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vid_code,
  input  logic [SEL_W-1:0]  sel_hi,
  input  logic [SEL_W-1:0]  sel_lo,
  input  logic              suspend,
  output logic [CODE_W-1:0] target,
  output logic              start
);
  localparam int SUS_W = 2 * SEL_W;

  logic [SUS_W-1:0]  sus_raw;
  logic [CODE_W-1:0] sus_code;
  logic [CODE_W-1:0] tgt_prev_q;
  logic              sus_prev_q;

  assign sus_raw  = {sel_hi, sel_lo};
  assign sus_code = CODE_W'(sus_raw);
  assign target   = suspend ? sus_code : vid_code;

  // a fresh transition whenever the target or the suspend level moves
  assign start = (target != tgt_prev_q) || (suspend != sus_prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_prev_q <= target;
      sus_prev_q <= suspend;
    end else begin
      tgt_prev_q <= target;
      sus_prev_q <= suspend;
    end
  end

  // R1: in suspend the target never exceeds the selector range
  a_r1_sus_range: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> (target < CODE_W'(1 << SUS_W)));
endmodule

// File: rtl/vss_ramp.sv
module vss_ramp
  import vid_slew_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int BLANK_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] dac_code,
  output phase_e            phase
);
  localparam int CNT_W = (BLANK_TICKS > 1) ? $clog2(BLANK_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLANK_TICKS - 1);

  logic [CODE_W-1:0] dac_q, dac_nxt;
  phase_e            ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              seen_q;

  always_comb begin
    if (target > dac_q)      dac_nxt = dac_q + CODE_W'(1);
    else if (target < dac_q) dac_nxt = dac_q - CODE_W'(1);
    else                     dac_nxt = dac_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_q  <= target;
      ph_q   <= PH_BLANK;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (start) begin
        cnt_q <= '0;
        case (ph_q)
          PH_IDLE:            ph_q <= PH_DELAY;
          PH_TRAIL, PH_BLANK: ph_q <= PH_STEP;
          default:            ph_q <= ph_q;
        endcase
      end else if (tick) begin
        case (ph_q)
          PH_DELAY: ph_q <= PH_STEP;
          PH_STEP: begin
            dac_q <= dac_nxt;
            if (dac_nxt == target) ph_q <= PH_TRAIL;
          end
          PH_TRAIL: begin
            ph_q  <= PH_BLANK;
            cnt_q <= '0;
          end
          PH_BLANK: begin
            if (cnt_q == CNT_LAST) ph_q <= PH_IDLE;
            else                   cnt_q <= cnt_q + CNT_W'(1);
          end
          default: ph_q <= ph_q;
        endcase
      end
    end
  end

  assign dac_code = dac_q;
  assign phase    = ph_q;

  // R3: moves only on a strobe and by a single code
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && (dac_q != $past(dac_q))) |->
      ($past(tick) && ((dac_q == $past(dac_q) + CODE_W'(1)) ||
                       (dac_q + CODE_W'(1) == $past(dac_q)))));

  // R4: the delay phase never steps
  a_r4_delay_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ph_q == PH_DELAY) |=> (dac_q == $past(dac_q)));
endmodule

// File: rtl/vss_mode.sv
module vss_mode
  import vid_slew_pkg::*;
(
  input  phase_e phase,
  input  logic   start,
  input  logic   suspend,
  input  logic   skip_req,
  output logic   pgood_oe,
  output logic   force_pwm
);
  logic idle;

  assign idle      = (phase == PH_IDLE) && !start;
  assign pgood_oe  = idle;
  assign force_pwm = !idle || (!suspend && skip_req);
endmodule

// File: rtl/vid_slew_seq.sv
module vid_slew_seq
  import vid_slew_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SEL_W       = 2,
  parameter int BLANK_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slew_tick,
  input  logic [CODE_W-1:0] vid_code,
  input  logic [SEL_W-1:0]  sus_sel_hi,
  input  logic [SEL_W-1:0]  sus_sel_lo,
  input  logic              suspend,
  input  logic              skip_req,
  output logic [CODE_W-1:0] dac_code,
  output logic              pgood_oe,
  output logic              force_pwm
);
  logic [CODE_W-1:0] target;
  logic              start;
  phase_e            phase;

  vss_target_sel #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .vid_code(vid_code), .sel_hi(sus_sel_hi),
    .sel_lo(sus_sel_lo), .suspend(suspend), .target(target), .start(start)
  );

  vss_ramp #(.CODE_W(CODE_W), .BLANK_TICKS(BLANK_TICKS)) u_ramp (
    .clk(clk), .rst_n(rst_n), .tick(slew_tick), .start(start),
    .target(target), .dac_code(dac_code), .phase(phase)
  );

  vss_mode u_mode (
    .phase(phase), .start(start), .suspend(suspend), .skip_req(skip_req),
    .pgood_oe(pgood_oe), .force_pwm(force_pwm)
  );

  // R6: power-good is only released with the code on target
  a_r6_on_target: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_oe |-> (dac_code == target));

  // R5: a start keeps power-good blanked into the next cycle
  a_r5_blank_next: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !pgood_oe);

  // R6: blanking always comes with forced PWM
  a_r6_pwm_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !pgood_oe |-> force_pwm);

  // R7: settled in suspend means pulse-skipping
  a_r7_skip_sus: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood_oe && suspend) |-> !force_pwm);
endmodule

// File: tb/tb_vid_slew_seq.sv
module tb_vid_slew_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slew_tick = 1'b0;
  logic [5:0] vid_code = 6'd20;
  logic [1:0] sus_sel_hi = 2'd0;
  logic [1:0] sus_sel_lo = 2'd0;
  logic       suspend = 1'b0;
  logic       skip_req = 1'b1;
  logic [5:0] dac_code;
  logic       pgood_oe;
  logic       force_pwm;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  vid_slew_seq dut (
    .clk(clk), .rst_n(rst_n), .slew_tick(slew_tick), .vid_code(vid_code),
    .sus_sel_hi(sus_sel_hi), .sus_sel_lo(sus_sel_lo), .suspend(suspend),
    .skip_req(skip_req), .dac_code(dac_code), .pgood_oe(pgood_oe),
    .force_pwm(force_pwm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: 0 idle, 1 delay, 2 step, 3 trail, 4 blank
  int m_dac, m_ph, m_cnt, m_ptgt, m_psus;

  function automatic int tgt_now();
    return suspend ? (int'(sus_sel_hi) * 4 + int'(sus_sel_lo)) : int'(vid_code);
  endfunction

  function automatic bit start_now();
    return (tgt_now() != m_ptgt) || (int'(suspend) != m_psus);
  endfunction

  always @(posedge clk) begin
    int t;
    t = tgt_now();
    if (!rst_n) begin
      m_dac = t; m_ph = 4; m_cnt = 0;
    end else if (start_now()) begin
      m_cnt = 0;
      if (m_ph == 0) m_ph = 1;
      else if (m_ph >= 3) m_ph = 2;
    end else if (slew_tick) begin
      if (m_ph == 1) m_ph = 2;
      else if (m_ph == 2) begin
        if (t > m_dac) m_dac++;
        else if (t < m_dac) m_dac--;
        if (m_dac == t) m_ph = 3;
      end else if (m_ph == 3) begin
        m_ph = 4; m_cnt = 0;
      end else if (m_ph == 4) begin
        m_cnt++;
        if (m_cnt == 8) m_ph = 0;
      end
    end
    m_ptgt = t;
    m_psus = int'(suspend);
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit idle;
      idle = (m_ph == 0) && !start_now();
      chk("R3 dac_code", int'(dac_code), m_dac);
      chk("R6 pgood_oe", int'(pgood_oe), int'(idle));
      chk("R8 force_pwm", int'(force_pwm), int'(!idle || (!suspend && skip_req)));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(int n);
    repeat (n) begin
      @(posedge clk); #1 slew_tick = 1'b1;
      @(posedge clk); #1 slew_tick = 1'b0;
    end
  endtask

  task automatic settle();
    for (int i = 0; i < 80; i++) begin
      if (pgood_oe) break;
      pulse(1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    @(posedge clk); #1 rst_n = 1'b1;
    #2;
    chk("R10 reset dac", int'(dac_code), 20);
    chk("R10 reset blank", int'(pgood_oe), 0);
    pulse(7);
    chk("R10 blank 7 ticks", int'(pgood_oe), 0);
    pulse(1);
    chk("R10 released", int'(pgood_oe), 1);
    chk("R8 skip high", int'(force_pwm), 1);

    // upward ramp with delay and trailing period
    vid_code = 6'd23; #2;
    chk("R5 blank at start", int'(pgood_oe), 0);
    chk("R5 pwm at start", int'(force_pwm), 1);
    pulse(1);
    chk("R4 delay no step", int'(dac_code), 20);
    pulse(1);
    chk("R3 first step", int'(dac_code), 21);
    pulse(2);
    chk("R3 reached", int'(dac_code), 23);
    pulse(8);
    chk("R6 still blank", int'(pgood_oe), 0);
    pulse(1);
    chk("R6 released", int'(pgood_oe), 1);

    // downward with skip low
    skip_req = 1'b0; vid_code = 6'd18; cyc(1);
    settle();
    chk("R3 down target", int'(dac_code), 18);
    chk("R8 skip low", int'(force_pwm), 0);

    // suspend entry
    skip_req = 1'b1; sus_sel_hi = 2'd2; sus_sel_lo = 2'd3; suspend = 1'b1; #2;
    chk("R5 sus pwm", int'(force_pwm), 1);
    pulse(3);
    vid_code = 6'd40;
    settle();
    chk("R2 sus code", int'(dac_code), 11);
    chk("R7 pulse skip", int'(force_pwm), 0);
    vid_code = 6'd5; cyc(4);
    chk("R1 vid ignored pg", int'(pgood_oe), 1);
    pulse(3);
    chk("R1 vid ignored dac", int'(dac_code), 11);

    // suspend exit
    suspend = 1'b0; #2;
    chk("R5 exit pwm", int'(force_pwm), 1);
    chk("R5 exit blank", int'(pgood_oe), 0);
    settle();
    chk("R1 vid target", int'(dac_code), 5);

    // mid-ramp retarget
    vid_code = 6'd15; cyc(1);
    pulse(4);
    chk("R9 mid ramp", int'(dac_code), 8);
    vid_code = 6'd2; cyc(1);
    pulse(1);
    chk("R9 continue no delay", int'(dac_code), 7);
    settle();
    chk("R9 final", int'(dac_code), 2);

    // retarget during blanking
    vid_code = 6'd4; cyc(1);
    pulse(9);
    chk("R9 in blank", int'(pgood_oe), 0);
    vid_code = 6'd3; cyc(1);
    pulse(2);
    chk("R9 back on", int'(dac_code), 3);
    pulse(7);
    chk("R9 count restart", int'(pgood_oe), 0);
    pulse(1);
    chk("R9 released", int'(pgood_oe), 1);

    // mixed activity under the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 4) vid_code = 6'($urandom_range(0, 63));
      else if (r < 6) suspend = ~suspend;
      else if (r < 8) {sus_sel_hi, sus_sel_lo} = 4'($urandom_range(0, 15));
      else if (r < 10) skip_req = ~skip_req;
      slew_tick = ($urandom_range(0, 2) == 0);
      cyc(1);
    end
    slew_tick = 1'b0;
    cyc(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule